// File: doc/BRIEF.md
# Global-History Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken, using only the outcomes of the most recent branches. A shift register holds those outcomes. Its current value selects one entry in a table of two-bit saturating counters, one counter for each possible history pattern. The guess is taken when the selected counter is in either of its two upper states. The branch address plays no part in choosing the entry.

The front end raises `pred_valid` and reads `pred_taken` in the same cycle. It keeps the returned `pred_hist` snapshot with the branch. When the branch resolves, the back end presents the real outcome and the saved snapshot on the resolve port. The counter selected by that snapshot is trained, and the outcome is shifted into the live history. After a misprediction, the flush port overwrites the history with a corrected value.

Each counter is a small state machine with four named states:
- `CTR_SNT` (00, strongly not-taken)
- `CTR_WNT` (01, weakly not-taken)
- `CTR_WT` (10, weakly taken)
- `CTR_ST` (11, strongly taken)

A taken outcome moves a counter one step up: SNT→WNT, WNT→WT, WT→ST, and ST→ST. A not-taken outcome moves it one step down: ST→WT, WT→WNT, WNT→SNT, and SNT→SNT. Without an update, the counter holds its state.

The history register has three modes, named `HM_HOLD`, `HM_SHIFT` and `HM_LOAD`. `HM_LOAD` (flush) has priority over `HM_SHIFT` (resolve), and `HM_HOLD` applies otherwise.

Top module: `glob_hist_predictor`

## Requirements
- R1: After reset the history is all zeros and every counter is in `CTR_WNT` (01), so every pattern first predicts not-taken.
- R2: With `pred_valid` high, `pred_taken` is 1 exactly when the counter indexed by the current history is 10 or 11, in the same cycle. `pred_hist` shows the current history.
- R3: While `pred_valid` is low, `pred_taken` is 0.
- R4: A taken resolve moves the counter at `res_hist` one step up and saturates at 11.
- R5: A not-taken resolve moves the counter at `res_hist` one step down and saturates at 00.
- R6: From 00, two taken resolves are needed before that pattern predicts taken. From 11, two not-taken resolves are needed before it predicts not-taken.
- R7: One cycle after a resolve without flush, the history equals the old history shifted left by one with `res_taken` in bit 0.
- R8: Training uses `res_hist`, not the live history.
- R9: A prediction made in the same cycle as a resolve sees the table and history as they were before that resolve.
- R10: One cycle after `flush_valid`, the history equals `flush_hist`, even when a resolve arrives in the same cycle. That resolve still trains its counter.
- R11: In a cycle with neither a resolve nor a flush, the history and all counters are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pred_valid | input | 1 | Prediction request |
| pred_taken | output | 1 | Predicted direction (1 = taken) |
| pred_hist | output | HW | History snapshot used for the index |
| res_valid | input | 1 | Resolve strobe |
| res_taken | input | 1 | Actual outcome (1 = taken) |
| res_hist | input | HW | Snapshot returned at prediction time |
| flush_valid | input | 1 | Overwrite the history |
| flush_hist | input | HW | Restore value for the history |

## Verification
The bench builds the block with a four-bit history, which gives a 16-entry table. At that size, every counter can be swept from reset through a flush to each pattern. Each counter can also be driven into both saturation limits within a few dozen cycles. The small history space means that a pseudo-random mix of resolves, flushes and predictions revisits the same entries often. Training under a stale snapshot and same-cycle predict/resolve collisions therefore occur many times in a short run.

// File: rtl/gh2l_pkg.sv
package gh2l_pkg;

    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_e;

    typedef enum logic [1:0] {
        HM_HOLD  = 2'b00,
        HM_SHIFT = 2'b01,
        HM_LOAD  = 2'b10
    } hmode_e;

    localparam ctr_e CTR_RESET = CTR_WNT;

endpackage

// File: rtl/gh2l_sat_ctr.sv
module gh2l_sat_ctr
    import gh2l_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic upd_en,
    input  logic upd_taken,
    output logic dir_taken
);

    ctr_e state_q;
    ctr_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CTR_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (upd_en) begin
            unique case (state_q)
                CTR_SNT: state_d = upd_taken ? CTR_WNT : CTR_SNT;
                CTR_WNT: state_d = upd_taken ? CTR_WT  : CTR_SNT;
                CTR_WT:  state_d = upd_taken ? CTR_ST  : CTR_WNT;
                CTR_ST:  state_d = upd_taken ? CTR_ST  : CTR_WT;
                default: state_d = CTR_RESET;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            CTR_SNT: dir_taken = 1'b0;
            CTR_WNT: dir_taken = 1'b0;
            CTR_WT:  dir_taken = 1'b1;
            CTR_ST:  dir_taken = 1'b1;
            default: dir_taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/gh2l_pht.sv
module gh2l_pht #(
    parameter int HW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_en,
    input  logic [HW-1:0] upd_idx,
    input  logic          upd_taken,
    input  logic [HW-1:0] rd_idx,
    output logic          rd_taken
);

    localparam int NENT = 1 << HW;

    logic [NENT-1:0] dir_vec;

    for (genvar e = 0; e < NENT; e++) begin : g_ent
        logic hit;
        assign hit = upd_en && (upd_idx == HW'(e));
        gh2l_sat_ctr u_ctr (
            .clk       (clk),
            .rst_n     (rst_n),
            .upd_en    (hit),
            .upd_taken (upd_taken),
            .dir_taken (dir_vec[e])
        );
    end

    assign rd_taken = dir_vec[rd_idx];

endmodule

// File: rtl/gh2l_hist.sv
module gh2l_hist
    import gh2l_pkg::*;
#(
    parameter int HW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic          shift_bit,
    input  logic          load_en,
    input  logic [HW-1:0] load_val,
    output logic [HW-1:0] hist
);

    hmode_e        mode;
    logic [HW-1:0] hist_q;
    logic [HW-1:0] hist_d;

    always_comb begin
        if (load_en) begin
            mode = HM_LOAD;
        end else if (shift_en) begin
            mode = HM_SHIFT;
        end else begin
            mode = HM_HOLD;
        end
    end

    always_comb begin
        unique case (mode)
            HM_HOLD:  hist_d = hist_q;
            HM_SHIFT: hist_d = {hist_q[HW-2:0], shift_bit};
            HM_LOAD:  hist_d = load_val;
            default:  hist_d = hist_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    assign hist = hist_q;

endmodule

// File: rtl/glob_hist_predictor.sv
module glob_hist_predictor #(
    parameter int HW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pred_valid,
    output logic          pred_taken,
    output logic [HW-1:0] pred_hist,
    input  logic          res_valid,
    input  logic          res_taken,
    input  logic [HW-1:0] res_hist,
    input  logic          flush_valid,
    input  logic [HW-1:0] flush_hist
);

    logic [HW-1:0] cur_hist;
    logic          tbl_taken;

    gh2l_hist #(.HW(HW)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (res_valid),
        .shift_bit (res_taken),
        .load_en   (flush_valid),
        .load_val  (flush_hist),
        .hist      (cur_hist)
    );

    gh2l_pht #(.HW(HW)) u_pht (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (res_valid),
        .upd_idx   (res_hist),
        .upd_taken (res_taken),
        .rd_idx    (cur_hist),
        .rd_taken  (tbl_taken)
    );

    assign pred_taken = pred_valid & tbl_taken;
    assign pred_hist  = cur_hist;

endmodule

// File: rtl/gh2l_chk.sv
module gh2l_chk #(
    parameter int HW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pred_valid,
    input logic          pred_taken,
    input logic [HW-1:0] pred_hist,
    input logic          res_valid,
    input logic          res_taken,
    input logic [HW-1:0] res_hist,
    input logic          flush_valid,
    input logic [HW-1:0] flush_hist
);

    // R3
    pred_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_valid |-> !pred_taken);

    // R7
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !flush_valid) |=>
            pred_hist == {$past(pred_hist[HW-2:0]), $past(res_taken)});

    // R10
    flush_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |=> pred_hist == $past(flush_hist));

    // R11
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_valid && !flush_valid) |=> $stable(pred_hist));

    // R4
    taken_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid && pred_taken && res_valid && res_taken &&
         res_hist == pred_hist && flush_valid && flush_hist == pred_hist)
        |=> (!pred_valid || pred_taken));

    // R5
    nt_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_valid && !pred_taken && res_valid && !res_taken &&
         res_hist == pred_hist && flush_valid && flush_hist == pred_hist)
        |=> (!pred_valid || !pred_taken));

endmodule

bind glob_hist_predictor gh2l_chk #(.HW(HW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pred_valid  (pred_valid),
    .pred_taken  (pred_taken),
    .pred_hist   (pred_hist),
    .res_valid   (res_valid),
    .res_taken   (res_taken),
    .res_hist    (res_hist),
    .flush_valid (flush_valid),
    .flush_hist  (flush_hist)
);

// File: tb/glob_hist_predictor_bench.sv
module glob_hist_predictor_bench;

    localparam int BH = 4;
    localparam int NE = 1 << BH;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pred_valid = 1'b0;
    logic          pred_taken;
    logic [BH-1:0] pred_hist;
    logic          res_valid = 1'b0;
    logic          res_taken = 1'b0;
    logic [BH-1:0] res_hist = '0;
    logic          flush_valid = 1'b0;
    logic [BH-1:0] flush_hist = '0;

    always #5 clk = ~clk;

    glob_hist_predictor #(.HW(BH)) u_glob_hist_predictor (
        .clk         (clk),
        .rst_n       (rst_n),
        .pred_valid  (pred_valid),
        .pred_taken  (pred_taken),
        .pred_hist   (pred_hist),
        .res_valid   (res_valid),
        .res_taken   (res_taken),
        .res_hist    (res_hist),
        .flush_valid (flush_valid),
        .flush_hist  (flush_hist)
    );

    int unsigned   n_cmp = 0;
    int unsigned   n_bad = 0;
    bit            done = 1'b0;
    logic [BH:0]   exp_q[$];
    string         tag_q[$];
    logic [1:0]    m_ctr [NE];
    logic [BH-1:0] m_hist;

    // Reference model update, applied for the coming clock edge.
    task automatic model_adv(input bit rv, input bit rt, input logic [BH-1:0] rh,
                             input bit fv, input logic [BH-1:0] fh);
        if (rv) begin
            if (rt && m_ctr[rh] != 2'b11) m_ctr[rh] = m_ctr[rh] + 2'd1;
            if (!rt && m_ctr[rh] != 2'b00) m_ctr[rh] = m_ctr[rh] - 2'd1;
        end
        if (fv) m_hist = fh;
        else if (rv) m_hist = {m_hist[BH-2:0], rt};
    endtask

    // Driver: one cycle of stimulus; expected prediction pushed to scoreboard.
    task automatic step(input bit pv, input bit rv, input bit rt, input logic [BH-1:0] rh,
                        input bit fv, input logic [BH-1:0] fh, input string tag);
        @(negedge clk);
        pred_valid  = pv;
        res_valid   = rv;
        res_taken   = rt;
        res_hist    = rh;
        flush_valid = fv;
        flush_hist  = fh;
        if (pv) begin
            exp_q.push_back({m_ctr[m_hist][1], m_hist});
            tag_q.push_back(tag);
        end
        model_adv(rv, rt, rh, fv, fh);
    endtask

    task automatic predict(input string tag);
        step(1'b1, 1'b0, 1'b0, '0, 1'b0, '0, tag);
    endtask

    // Resolve at index ix while pinning the history to ix through a flush.
    task automatic train(input logic [BH-1:0] ix, input bit rt, input string tag);
        step(1'b0, 1'b1, rt, ix, 1'b1, ix, tag);
    endtask

    // Monitor: compares outputs against scoreboard away from the clock edge.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (pred_valid && rst_n) begin
                logic [BH:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if ({pred_taken, pred_hist} !== e) begin
                    n_bad++;
                    $display("FAIL %s: got taken=%0b hist=%0h, expected taken=%0b hist=%0h",
                             t, pred_taken, pred_hist, e[BH], e[BH-1:0]);
                end
            end else if (!pred_valid && rst_n) begin
                if (pred_taken !== 1'b0) begin
                    n_cmp++;
                    n_bad++;
                    $display("FAIL R3: got taken=%0b with request low, expected 0", pred_taken);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got run still active, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < NE; i++) m_ctr[i] = 2'b01;
        m_hist = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state at history zero
        predict("R1");
        // R1 R10: sweep every pattern through a flush
        for (int v = 0; v < NE; v++) begin
            step(1'b0, 1'b0, 1'b0, '0, 1'b1, BH'(v), "R10");
            predict("R1");
        end

        // R5 R6: drive entry 3 down to 00, then two taken resolves to flip
        train(4'd3, 1'b0, "R5");
        train(4'd3, 1'b0, "R5");
        train(4'd3, 1'b0, "R5");
        predict("R5");
        train(4'd3, 1'b1, "R6");
        predict("R6");
        train(4'd3, 1'b1, "R6");
        predict("R6");

        // R4 R6: saturate at 11, then two not-taken to flip back
        train(4'd3, 1'b1, "R4");
        train(4'd3, 1'b1, "R4");
        train(4'd3, 1'b0, "R4");
        predict("R4");
        train(4'd3, 1'b0, "R6");
        predict("R6");

        // R8: history at 3, train entry 9 with stale snapshot; entry 3 unchanged
        train(4'd9, 1'b1, "R8");
        step(1'b0, 1'b1, 1'b1, 4'd9, 1'b1, 4'd3, "R8");
        predict("R8");
        step(1'b0, 1'b0, 1'b0, '0, 1'b1, 4'd9, "R8");
        predict("R8");

        // R9: predict and resolve same index in same cycle
        train(4'd6, 1'b1, "R9");
        step(1'b1, 1'b1, 1'b1, 4'd6, 1'b1, 4'd6, "R9");
        predict("R9");

        // R7: plain resolve shifts outcome into history
        step(1'b0, 1'b1, 1'b1, 4'd0, 1'b0, '0, "R7");
        predict("R7");
        step(1'b0, 1'b1, 1'b0, 4'd0, 1'b0, '0, "R7");
        predict("R7");

        // R11: idle cycles change nothing; R3 request low checked by monitor
        step(1'b0, 1'b0, 1'b1, 4'd5, 1'b0, 4'd7, "R11");
        step(1'b0, 1'b0, 1'b1, 4'd5, 1'b0, 4'd7, "R11");
        predict("R11");
        step(1'b0, 1'b0, 1'b0, '0, 1'b1, 4'd6, "R3");
        step(1'b0, 1'b0, 1'b0, '0, 1'b0, '0, "R3");
        predict("R3");

        // R2: mixed pseudo-random traffic
        lfsr = 16'hACE1;
        for (int n = 0; n < 600; n++) begin
            logic [BH-1:0] rh;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rh = lfsr[3] ? m_hist : lfsr[11:8];
            step(lfsr[0] | lfsr[5], lfsr[1], lfsr[2] | lfsr[7], rh,
                 (lfsr[6:4] == 3'b101), lfsr[15:12], "R2");
        end

        step(1'b0, 1'b0, 1'b0, '0, 1'b0, '0, "R11");
        @(negedge clk);
        #4;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R2: got %0d unmatched predictions, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule